// File: doc/BRIEF.md
# Packed Lane Saturating Adder

This block adds two 64-bit operands lane by lane. A run-time lane-size code splits the word into eight bytes, four 16-bit halves, two 32-bit words or one 64-bit lane. A second control picks the overflow behaviour of every lane. In wrap mode a lane that overflows keeps only its low-order bits. In saturating mode a lane whose unsigned sum does not fit is clamped to its all-ones maximum. The operation is two-operand: the destination operand comes back as destination plus source. It is meant for the integer datapath of a packed media unit, for jobs such as brightening eight 8-bit pixels at once without the dark inversion that wraparound causes.

The carry chain is built from 8-bit slices. Between two slices the carry is cut whenever the upper slice starts a new lane. Each slice reads the carry-out of the top slice of its own lane. In saturating mode, a set carry forces the slice to ones. Output is registered. A two-state control machine has the states `ST_IDLE` (no result presented) and `ST_EMIT` (result presented). It has four transitions:
- `IDLE->EMIT` when `in_valid` is high.
- `IDLE->IDLE` when `in_valid` is low.
- `EMIT->EMIT` when `in_valid` is high again.
- `EMIT->IDLE` when `in_valid` is low.

Top module: `psa_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the control in `ST_IDLE`, so `out_valid` is 0 in the cycle after.
- R2: `lane_mode` selects the lane width: 0 = eight 8-bit lanes, 1 = four 16-bit lanes, 2 = two 32-bit lanes, 3 = one 64-bit lane. Lane k occupies bits [k*W+W-1 : k*W].
- R3: No carry passes from one lane into the next. With `lane_mode`=0, 0xFF+0x01 in byte 0 leaves byte 1 equal to its own sum.
- R4: With `sat_en`=0, each lane result is (dst_lane + src_lane) mod 2^W; for example 250+100 in an 8-bit lane gives 94.
- R5: With `sat_en`=1, a lane whose true sum exceeds 2^W-1 outputs all ones; for example 250+100 in an 8-bit lane gives 255.
- R6: With `sat_en`=1, a lane whose sum fits gives the exact sum (0+0 gives 0).
- R7: All-ones plus all-ones gives all ones except bit 0 of each lane (wrap) or all ones (saturating), for every lane width.
- R8: When `in_valid` is high at a clock edge, `out_valid` is 1 in the next cycle and `result` holds destination plus source for the operands sampled at that edge.
- R9: When `in_valid` is low at a clock edge, `out_valid` is 0 in the next cycle and `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls valid this cycle |
| lane_mode | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64 bits) |
| sat_en | input | 1 | 1 = unsigned saturating, 0 = wraparound |
| dst_in | input | 64 | Destination operand |
| src_in | input | 64 | Source operand |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Destination plus source, per lane |

## Verification
The case hardest to reach from the ports is a carry that arrives exactly at a lane boundary. It must cross the boundary in a wider mode and be cut in a narrower one. Only operands with all-ones runs that straddle a slice edge show the difference. The stimulus feeds the same patterns through all four lane codes and both overflow modes. These patterns are 0xFF+0x01 at each byte position, all-ones plus all-ones, and a lane of 0x..FF plus 1 under 16-bit and wider modes. A pseudo-random stream follows, checked against a per-lane reference model.

// File: rtl/psa_pkg.sv
package psa_pkg;
    localparam int DATA_W     = 64;
    localparam int SLICE_W    = 8;
    localparam int NUM_SLICES = DATA_W / SLICE_W;
    localparam int IDX_W      = $clog2(NUM_SLICES);
    localparam int MODE_W     = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } psa_state_e;
endpackage

// File: rtl/psa_carry_chain.sv
module psa_carry_chain
    import psa_pkg::*;
#(
    parameter int SW = SLICE_W,
    parameter int NS = NUM_SLICES,
    parameter int IW = IDX_W,
    parameter int MW = MODE_W
) (
    input  logic [SW*NS-1:0] op_a,
    input  logic [SW*NS-1:0] op_b,
    input  logic [MW-1:0]    lane_mode,
    output logic [SW*NS-1:0] slice_sum,
    output logic [NS-1:0]    slice_cout
);
    logic [IW-1:0] span_mask;
    logic [NS-1:0] cin;

    always_comb span_mask = IW'((32'd1 << lane_mode) - 32'd1);

    for (genvar i = 0; i < NS; i++) begin : g_slice
        logic [SW:0] wide;
        if (i == 0) begin : g_first
            assign cin[i] = 1'b0;
        end else begin : g_rest
            // a slice that begins a lane takes no carry from below
            assign cin[i] = ((IW'(i) & span_mask) == '0) ? 1'b0 : slice_cout[i-1];
        end
        assign wide = {1'b0, op_a[i*SW +: SW]} + {1'b0, op_b[i*SW +: SW]} + {{SW{1'b0}}, cin[i]};
        assign slice_sum[i*SW +: SW] = wide[SW-1:0];
        assign slice_cout[i] = wide[SW];

        // R3: in byte mode every slice is exactly its own byte sum
        always_comb begin
            if (lane_mode == '0)
                a_r3_no_cross: assert (slice_sum[i*SW +: SW] == SW'(op_a[i*SW +: SW] + op_b[i*SW +: SW]));
        end
    end
endmodule

// File: rtl/psa_clamp.sv
module psa_clamp
    import psa_pkg::*;
#(
    parameter int SW = SLICE_W,
    parameter int NS = NUM_SLICES,
    parameter int IW = IDX_W,
    parameter int MW = MODE_W
) (
    input  logic [SW*NS-1:0] slice_sum,
    input  logic [NS-1:0]    slice_cout,
    input  logic [MW-1:0]    lane_mode,
    input  logic             sat_en,
    output logic [SW*NS-1:0] lane_out
);
    logic [IW-1:0] span_mask;

    always_comb span_mask = IW'((32'd1 << lane_mode) - 32'd1);

    for (genvar i = 0; i < NS; i++) begin : g_slice
        logic [IW-1:0] top_idx;
        logic          lane_ovf;
        assign top_idx  = IW'(i) | span_mask;
        assign lane_ovf = slice_cout[top_idx];
        assign lane_out[i*SW +: SW] = (sat_en && lane_ovf) ? {SW{1'b1}} : slice_sum[i*SW +: SW];

        always_comb begin
            // R5: a saturating lane with a carry-out is all ones
            if (sat_en && slice_cout[top_idx])
                a_r5_sat_ones: assert (&lane_out[i*SW +: SW]);
            // R4: wrap mode passes the truncated sum unchanged
            if (sat_en == 1'b0)
                a_r4_wrap_pass: assert (lane_out[i*SW +: SW] == slice_sum[i*SW +: SW]);
        end
    end
endmodule

// File: rtl/psa_top.sv
module psa_top
    import psa_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [MODE_W-1:0]   lane_mode,
    input  logic                sat_en,
    input  logic [DATA_W-1:0]   dst_in,
    input  logic [DATA_W-1:0]   src_in,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result
);
    psa_state_e             state_q, state_d;
    logic [DATA_W-1:0]      sum_w;
    logic [NUM_SLICES-1:0]  cout_w;
    logic [DATA_W-1:0]      lane_w;
    logic [DATA_W-1:0]      result_q;

    psa_carry_chain u_chain (
        .op_a       (dst_in),
        .op_b       (src_in),
        .lane_mode  (lane_mode),
        .slice_sum  (sum_w),
        .slice_cout (cout_w)
    );

    psa_clamp u_clamp (
        .slice_sum  (sum_w),
        .slice_cout (cout_w),
        .lane_mode  (lane_mode),
        .sat_en     (sat_en),
        .lane_out   (lane_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           result_q <= '0;
        else if (in_valid) result_q <= lane_w;
    end

    assign out_valid = (state_q == ST_EMIT);
    assign result    = result_q;

    // R1: reset drops out_valid
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !out_valid);
    // R8: accepted operands yield a valid result next cycle
    a_r8_emit_next: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
    // R9: no input means no result and a held value
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));
endmodule

// File: tb/psa_top_tb_top.sv
module psa_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  lane_mode;
    logic        sat_en;
    logic [63:0] dst_in, src_in;
    logic        out_valid;
    logic [63:0] result;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    psa_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .lane_mode(lane_mode),
        .sat_en(sat_en), .dst_in(dst_in), .src_in(src_in),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] ref_add(input logic [63:0] a, input logic [63:0] b,
                                            input logic [1:0] m, input logic s);
        int w = 8 << m;
        logic [64:0] mask = ({65{1'b0}} | ((65'd1 << w) - 65'd1));
        logic [63:0] r = '0;
        for (int k = 0; k < 64 / w; k++) begin
            logic [64:0] la = ({1'b0, a} >> (k * w)) & mask;
            logic [64:0] lb = ({1'b0, b} >> (k * w)) & mask;
            logic [64:0] sm = la + lb;
            logic [64:0] lr = (s && sm > mask) ? mask : (sm & mask);
            r = r | 64'(lr << (k * w));
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, sample 1 ns after the capturing posedge
    task automatic run_op(input string req, input logic [1:0] m, input logic s,
                          input logic [63:0] a, input logic [63:0] b, input logic [63:0] exp);
        @(negedge clk);
        in_valid = 1'b1; lane_mode = m; sat_en = s; dst_in = a; src_in = b;
        @(posedge clk); #1;
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check(req, result, exp);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b1; lane_mode = '0; sat_en = 1'b0; dst_in = '1; src_in = '1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 out_valid in reset", 64'(out_valid), 64'd0);
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;
        @(posedge clk); #1;
        check("R1 out_valid after reset", 64'(out_valid), 64'd0);
    endtask

    task automatic t_byte_wrap_sat();
        logic [63:0] a = {8{8'd250}};
        logic [63:0] b = {8{8'd100}};
        run_op("R4 byte wrap 250+100", 2'd0, 1'b0, a, b, {8{8'd94}});
        run_op("R5 byte sat 250+100", 2'd0, 1'b1, a, b, {8{8'd255}});
        run_op("R6 sat zero+zero", 2'd0, 1'b1, '0, '0, '0);
        run_op("R6 sat fits", 2'd1, 1'b1, 64'h0010_0020_0030_0040, 64'h0001_0002_0003_0004,
               64'h0011_0022_0033_0044);
    endtask

    task automatic t_lane_isolation();
        for (int p = 0; p < 8; p++) begin
            logic [63:0] a = 64'hFF << (p * 8);
            logic [63:0] b = 64'h01 << (p * 8);
            run_op("R3 byte carry cut", 2'd0, 1'b0, a, b, 64'h0);
        end
        run_op("R2 16-bit carry crosses byte", 2'd1, 1'b0, 64'h0000_0000_0000_00FF,
               64'h1, 64'h0000_0000_0000_0100);
        run_op("R3 16-bit carry cut at lane", 2'd1, 1'b0, 64'h0000_0000_0000_FFFF,
               64'h1, 64'h0);
        run_op("R2 32-bit carry crosses half", 2'd2, 1'b0, 64'h0000_0000_0000_FFFF,
               64'h1, 64'h0000_0000_0001_0000);
        run_op("R3 32-bit carry cut at lane", 2'd2, 1'b0, 64'h0000_0000_FFFF_FFFF,
               64'h1, 64'h0);
        run_op("R2 64-bit full carry", 2'd3, 1'b0, 64'h0000_0000_FFFF_FFFF,
               64'h1, 64'h0000_0001_0000_0000);
        run_op("R5 16-bit lane sat", 2'd1, 1'b1, 64'h0000_0000_0000_FFF0,
               64'h0000_0000_0000_0020, 64'h0000_0000_0000_FFFF);
    endtask

    task automatic t_corners();
        for (int m = 0; m < 4; m++) begin
            logic [63:0] wexp = '1;
            for (int k = 0; k < 64 / (8 << m); k++) wexp[k * (8 << m)] = 1'b0;
            run_op("R7 ones+ones wrap", 2'(m), 1'b0, '1, '1, wexp);
            run_op("R7 ones+ones sat", 2'(m), 1'b1, '1, '1, '1);
            run_op("R6 zero+zero", 2'(m), 1'b1, '0, '0, '0);
        end
    endtask

    task automatic t_random();
        logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;
        for (int n = 0; n < 200; n++) begin
            logic [63:0] a, b;
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17); a = x;
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17); b = x;
            run_op("R8 random vs model", 2'(n % 4), 1'((n / 4) % 2), a, b,
                   ref_add(a, b, 2'(n % 4), 1'((n / 4) % 2)));
        end
    endtask

    task automatic t_idle_hold();
        logic [63:0] held;
        run_op("R8 before idle", 2'd0, 1'b0, 64'h0102_0304_0506_0708, 64'h1, 64'h0102_0304_0506_0709);
        held = result;
        @(negedge clk);
        in_valid = 1'b0; dst_in = '1; src_in = '1;
        @(posedge clk); #1;
        check("R9 out_valid low", 64'(out_valid), 64'd0);
        check("R9 result held", result, held);
    endtask

    initial begin
        t_reset();
        t_byte_wrap_sat();
        t_lane_isolation();
        t_corners();
        t_random();
        t_idle_hold();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule